// File: doc/BRIEF.md
# Dual-Processor Shared Control Register Bank

This block is a bank of eight byte-wide control and status registers that two processors share: a host processor and a secondary processor. Each side has its own port with a 3-bit offset, write data, a read strobe and a write strobe. Every bit has its own access rule. A bit may be writable from both sides, from one side only, read-only, or a constant. Reads are registered and return the bank's contents as they stood in the cycle of the strobe.

The bank decides which processor runs. A handoff bit can be set only by the host and cleared only by the secondary side. It drives a host-hold output and a secondary-run output, and a dual-run combination of two other bits overrides it. The bank also does the following:
- passes mailbox bits in both directions;
- shows three live inputs: the boot switch, the video switch and an unlocked status;
- latches a bus-timeout pulse until a read clears it;
- turns the status register into a stream of eight identification bytes while a mode bit is set.

It also drives a video-select line and two memory-mapping selects.

Top module: `dual_cpu_ctrl_bank`

## Requirements
- R1: Constant bits read fixed values from either port, whatever has been written. Offset 1 reads 0xFF. Offset 2 reads bits 7:6 as 1 and bits 5 and 0 as 0. Offset 5 reads bits 7, 6, 4 and 1 as 0. Offset 6 reads bit 0 as 0. Offset 7 reads bits 7:4 as 0.
- R2: After reset, offset 4 reads 0x80, offset 2 reads 0xC0, offset 1 reads 0xFF, and all other writable bits read 0. Host-hold and secondary-run are 0 after reset, so the host runs and the secondary processor is held in reset.
- R3: Write permission is set per bit.
  - Host-writable bits: offset 0 bits 7:0; offset 2 bits 4:1; offset 3 bits 7:6 and 3:0; offset 4 bits 6:1; offset 6 bits 7:1; offset 7 bits 3:0.
  - Secondary-writable bits: the same set, except that offset 3 bits 5:4 replace bits 7:6, and offset 4 bit 7 is added.
  - Offset 5 ignores writes from both sides.
- R4: Mailbox. Offset 3 bits 5:4 hold the values the secondary side last wrote there, and the host reads them. Offset 3 bits 7:6 hold the values the host last wrote there, and the secondary side reads them.
- R5: Handoff bit (offset 4 bit 0).
  - A host write with data bit 0 = 1 sets it; a host write with 0 leaves it unchanged.
  - A secondary write with data bit 0 = 0 clears it; a secondary write with 1 leaves it unchanged.
  - While the bit is set and dual-run is off, host_hold = 1 and sec_run = 1. While it is clear, both outputs are 0.
- R6: Dual-run. While offset 4 bits 1 and 3 are both 1, host_hold = 0 and sec_run = 1, whatever the value of bit 0.
- R7: Offset 5 bit 3 is set one cycle after a bus_timeout pulse. A read of offset 5 from either port clears it. If a pulse and a clearing read fall in the same cycle, the flag ends up set, and that read returns the value the flag had before.
- R8: Identification stream.
  - While offset 4 bit 4 is 1, reads of offset 5 return D5, 7F, 00, AA, 55, FF, 80, 2A in turn.
  - The stream advances by one for each cycle that has a read of offset 5 from either port, and wraps after 2A.
  - When both ports read offset 5 in the same cycle, both get the same byte.
  - The stream restarts at D5 whenever bit 4 has been 0.
- R9: While the identification stream is off, offset 5 reads bit 0 = sw_pc_boot, bit 2 = sw_video and bit 5 = unlocked_in, all sampled in the cycle of the read strobe.
- R10: Same-cycle writes to one offset.
  - A bit that both sides may write takes the secondary value.
  - A bit that only one side may write takes that side's value.
  - For the handoff bit, a secondary clear wins over a host set.
- R11: aux_rom_en = offset 3 bit 0, win_en = offset 3 bit 1, cart_map = offset 4 bit 1, video_sel = offset 4 bit 2.
- R12: Read data changes only in the cycle after a read strobe. It holds the register value from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 3 | Host register offset |
| h_wdata | input | 8 | Host write data |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_rdata | output | 8 | Host read data, registered |
| s_addr | input | 3 | Secondary register offset |
| s_wdata | input | 8 | Secondary write data |
| s_rd | input | 1 | Secondary read strobe |
| s_wr | input | 1 | Secondary write strobe |
| s_rdata | output | 8 | Secondary read data, registered |
| sw_pc_boot | input | 1 | Boot switch, 1 = host boots |
| sw_video | input | 1 | Video switch position |
| unlocked_in | input | 1 | Secondary hardware unlocked status |
| bus_timeout | input | 1 | One-cycle pulse on a timed-out host access to the secondary bus |
| host_hold | output | 1 | Holds the host processor |
| sec_run | output | 1 | Releases the secondary processor from reset |
| video_sel | output | 1 | Video source select |
| cart_map | output | 1 | Selects the cartridge instead of the boot ROM at the secondary's address 0 |
| aux_rom_en | output | 1 | Enables the auxiliary ROM on the secondary side |
| win_en | output | 1 | Enables the host's memory window into the secondary's address space |

## Verification
Three pairs of functions can land in the same cycle, and the bench drives each pair through both ports in one step, then judges the results against a cycle-by-cycle model kept in the bench.

- **Timeout pulse and clearing read.** The bench raises bus_timeout while a port reads offset 5. The returned byte must show the old flag, and the next read must show the flag set.
- **Host set and secondary clear.** The two ports write offset 4 in the same step, with the host setting the handoff bit and the secondary clearing it. Both the read-back and host_hold/sec_run must show the clear winning.
- **Two reads of the identification stream.** Both ports read offset 5 in the same cycle. The bench expects equal bytes and a single advance of the stream.

// File: rtl/ctrl_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, per-offset access masks and the identification
// byte table of the dual-processor control register bank.
// Assumes eight byte-wide registers addressed by a 3-bit offset.
package ctrl_bank_pkg;
    localparam int DW     = 8;
    localparam int NREG   = 8;
    localparam int AW     = $clog2(NREG);
    localparam int ID_LEN = 8;

    localparam int OFS_MAIL   = 3;
    localparam int OFS_HANDOF = 4;
    localparam int OFS_STAT   = 5;

    localparam int BIT_RUN  = 0;
    localparam int BIT_MAP  = 1;
    localparam int BIT_VID  = 2;
    localparam int BIT_DUAL = 3;
    localparam int BIT_ID   = 4;

    typedef logic [DW-1:0] byte_t;

    // Bits the host side may write at a given offset.
    function automatic byte_t host_wmask(input int ofs);
        case (ofs)
            0:       return 8'hFF;
            2:       return 8'h1E;
            3:       return 8'hCF;
            4:       return 8'h7E;
            6:       return 8'hFE;
            7:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    // Bits the secondary side may write at a given offset.
    function automatic byte_t sec_wmask(input int ofs);
        case (ofs)
            0:       return 8'hFF;
            2:       return 8'h1E;
            3:       return 8'h3F;
            4:       return 8'hFE;
            6:       return 8'hFE;
            7:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of the stored (writable) bits.
    function automatic byte_t store_reset(input int ofs);
        return (ofs == OFS_HANDOF) ? 8'h80 : 8'h00;
    endfunction

    // Bits that always read as one.
    function automatic byte_t const_ones(input int ofs);
        case (ofs)
            1:       return 8'hFF;
            2:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    // Identification byte at a stream position.
    function automatic byte_t id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'hD5;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h00;
            3'd3:    return 8'hAA;
            3'd4:    return 8'h55;
            3'd5:    return 8'hFF;
            3'd6:    return 8'h80;
            default: return 8'h2A;
        endcase
    endfunction
endpackage

// File: rtl/cb_reg_cell.sv
`timescale 1ns/1ps
// Module: one byte register with per-bit write permission for two ports.
// Host write applies first, then the secondary write, so the secondary side
// wins on bits both may write. Bits outside both masks keep their reset value.
module cb_reg_cell #(
    parameter int          W     = 8,
    parameter logic [W-1:0] HMASK = '0,
    parameter logic [W-1:0] SMASK = '0,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         h_we,
    input  logic [W-1:0] h_wd,
    input  logic         s_we,
    input  logic [W-1:0] s_wd,
    output logic [W-1:0] q
);
    logic [W-1:0] after_h;
    logic [W-1:0] nxt;

    // Merge host then secondary write data under each side's mask.
    always_comb begin
        after_h = h_we ? ((q & ~HMASK) | (h_wd & HMASK)) : q;
        nxt     = s_we ? ((after_h & ~SMASK) | (s_wd & SMASK)) : after_h;
    end

    // Register the merged byte.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= nxt;
    end

    // R3: with no write strobe the byte does not move.
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_we && !s_we) |=> $stable(q));
    // R10: secondary data lands on bits only the secondary may write.
    a_r10_sec_bits: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |=> ((q & SMASK) == ($past(s_wd) & SMASK)));
endmodule

// File: rtl/cb_handoff.sv
`timescale 1ns/1ps
// Module: processor handoff bit and run/hold decode.
// The host can only set the bit and the secondary side can only clear it.
// A same-cycle secondary clear wins. The dual-run pair overrides the bit.
module cb_handoff (
    input  logic clk,
    input  logic rst_n,
    input  logic h_set,
    input  logic h_val,
    input  logic s_clr,
    input  logic s_val,
    input  logic map_bit,
    input  logic dual_bit,
    output logic run_bit,
    output logic host_hold,
    output logic sec_run
);
    logic after_h;
    logic both_free;

    // Host may only raise, secondary may only lower.
    always_comb begin
        after_h = h_set ? (run_bit | h_val) : run_bit;
    end

    // Hold the handoff bit.
    always_ff @(posedge clk) begin
        if (!rst_n) run_bit <= 1'b0;
        else        run_bit <= after_h & (s_clr ? s_val : 1'b1);
    end

    // Decode which processor runs.
    always_comb begin
        both_free = map_bit & dual_bit;
        host_hold = run_bit & ~both_free;
        sec_run   = run_bit | both_free;
    end

    // R5: a host set without a secondary clear lands.
    a_r5_host_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (h_set && h_val && !(s_clr && !s_val)) |=> run_bit);
    // R5: a secondary clear always lands (R10 when both write).
    a_r5_sec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clr && !s_val) |=> !run_bit);
    // R5: only a secondary write can lower the bit.
    a_r5_fall_by_sec: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_bit) |-> $past(s_clr));
endmodule

// File: rtl/cb_status.sv
`timescale 1ns/1ps
// Module: latched bus-timeout flag and identification stream position.
// A set pulse wins over a clearing read in the same cycle. The position
// restarts while the identification mode is off.
module cb_status #(
    parameter int SEQ_LEN = 8,
    localparam int IW     = $clog2(SEQ_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          timeout_pulse,
    input  logic          rd_hit,
    input  logic          id_mode,
    output logic          to_flag,
    output logic [IW-1:0] idx
);
    // Timeout flag: set wins over read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             to_flag <= 1'b0;
        else if (timeout_pulse) to_flag <= 1'b1;
        else if (rd_hit)        to_flag <= 1'b0;
    end

    // Stream position: restart when mode is off, step once per read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !id_mode)  idx <= '0;
        else if (rd_hit)         idx <= (idx == IW'(SEQ_LEN - 1)) ? '0 : idx + 1'b1;
    end

    // R7: a pulse is never lost.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> to_flag);
    // R7: a read without a pulse clears.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !timeout_pulse) |=> !to_flag);
    // R8: mode off restarts the stream.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |=> (idx == '0));
    // R8: without a read the position holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !rd_hit) |=> $stable(idx));
endmodule

// File: rtl/cb_read_port.sv
`timescale 1ns/1ps
// Module: registered read port selecting one byte of the bank view.
// Data updates only on a read strobe and holds otherwise.
module cb_read_port #(
    parameter int W = 8,
    parameter int N = 8,
    localparam int AWL = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd,
    input  logic [AWL-1:0] addr,
    input  logic [W-1:0]   view [N],
    output logic [W-1:0]   rdata
);
    // Capture the addressed byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= view[addr];
    end

    // R12: read data moves only after a strobe.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/dual_cpu_ctrl_bank.sv
`timescale 1ns/1ps
// Module: top of the dual-processor shared control register bank.
// Eight byte registers with per-bit, per-port access rules. The bank holds
// the processor handoff, mailbox bits, switch/status inputs, a read-cleared
// timeout flag and an identification byte stream. Assumes both ports share clk.
module dual_cpu_ctrl_bank
    import ctrl_bank_pkg::*;
#(
    parameter int SEQ_LEN = ID_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_rd,
    input  logic          h_wr,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    input  logic          s_rd,
    input  logic          s_wr,
    output logic [DW-1:0] s_rdata,
    input  logic          sw_pc_boot,
    input  logic          sw_video,
    input  logic          unlocked_in,
    input  logic          bus_timeout,
    output logic          host_hold,
    output logic          sec_run,
    output logic          video_sel,
    output logic          cart_map,
    output logic          aux_rom_en,
    output logic          win_en
);
    localparam int IW = $clog2(SEQ_LEN);

    logic [DW-1:0] cell_q [NREG];
    logic [DW-1:0] view   [NREG];
    logic          run_bit;
    logic          to_flag;
    logic [IW-1:0] id_idx;
    logic          stat_rd;

    // Per-offset storage with its own access masks.
    for (genvar g = 0; g < NREG; g++) begin : g_cell
        cb_reg_cell #(
            .W    (DW),
            .HMASK(host_wmask(g)),
            .SMASK(sec_wmask(g)),
            .RST  (store_reset(g))
        ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .h_we (h_wr && (h_addr == AW'(g))),
            .h_wd (h_wdata),
            .s_we (s_wr && (s_addr == AW'(g))),
            .s_wd (s_wdata),
            .q    (cell_q[g])
        );
    end

    cb_handoff u_handoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_set    (h_wr && (h_addr == AW'(OFS_HANDOF))),
        .h_val    (h_wdata[BIT_RUN]),
        .s_clr    (s_wr && (s_addr == AW'(OFS_HANDOF))),
        .s_val    (s_wdata[BIT_RUN]),
        .map_bit  (cell_q[OFS_HANDOF][BIT_MAP]),
        .dual_bit (cell_q[OFS_HANDOF][BIT_DUAL]),
        .run_bit  (run_bit),
        .host_hold(host_hold),
        .sec_run  (sec_run)
    );

    // Any port reading the status offset.
    always_comb begin
        stat_rd = (h_rd && (h_addr == AW'(OFS_STAT))) ||
                  (s_rd && (s_addr == AW'(OFS_STAT)));
    end

    cb_status #(.SEQ_LEN(SEQ_LEN)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .timeout_pulse(bus_timeout),
        .rd_hit       (stat_rd),
        .id_mode      (cell_q[OFS_HANDOF][BIT_ID]),
        .to_flag      (to_flag),
        .idx          (id_idx)
    );

    // Assemble the bank as seen by both readers.
    always_comb begin
        for (int i = 0; i < NREG; i++) view[i] = cell_q[i] | const_ones(i);
        view[OFS_HANDOF][BIT_RUN] = run_bit;
        if (cell_q[OFS_HANDOF][BIT_ID])
            view[OFS_STAT] = id_byte(3'(id_idx));
        else
            view[OFS_STAT] = {2'b00, unlocked_in, 1'b0, to_flag, sw_video, 1'b0, sw_pc_boot};
    end

    cb_read_port #(.W(DW), .N(NREG)) u_rd_host (
        .clk(clk), .rst_n(rst_n), .rd(h_rd), .addr(h_addr), .view(view), .rdata(h_rdata)
    );
    cb_read_port #(.W(DW), .N(NREG)) u_rd_sec (
        .clk(clk), .rst_n(rst_n), .rd(s_rd), .addr(s_addr), .view(view), .rdata(s_rdata)
    );

    // Drive the decoded control outputs.
    always_comb begin
        aux_rom_en = cell_q[OFS_MAIL][0];
        win_en     = cell_q[OFS_MAIL][1];
        cart_map   = cell_q[OFS_HANDOF][BIT_MAP];
        video_sel  = cell_q[OFS_HANDOF][BIT_VID];
    end

    // R1: offset 1 always reads all ones.
    a_r1_const_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_addr == 3'd1) |=> (h_rdata == 8'hFF));
    // R1: offset 2 constant bits on the secondary port.
    a_r1_const_ofs2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd && s_addr == 3'd2) |=> (s_rdata[7:5] == 3'b110 && !s_rdata[0]));
    // R3: a host-only write to offset 4 never moves bit 7.
    a_r3_lock_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == 3'd4 && !(s_wr && s_addr == 3'd4))
            |=> $stable(cell_q[OFS_HANDOF][7]));
endmodule

// File: tb/tb_dual_cpu_ctrl_bank.sv
`timescale 1ns/1ps
module tb_dual_cpu_ctrl_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] h_addr = '0, s_addr = '0;
    logic [7:0] h_wdata = '0, s_wdata = '0;
    logic       h_rd = 0, h_wr = 0, s_rd = 0, s_wr = 0;
    logic [7:0] h_rdata, s_rdata;
    logic       sw_pc_boot = 0, sw_video = 0, unlocked_in = 0, bus_timeout = 0;
    logic       host_hold, sec_run, video_sel, cart_map, aux_rom_en, win_en;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mreg [8];
    logic       tflag = 0;
    int         id_k  = 0;

    always #2.5 clk = ~clk;

    dual_cpu_ctrl_bank dut (.*);

    function automatic logic [7:0] hm(input int a);
        case (a)
            0: return 8'hFF; 2: return 8'h1E; 3: return 8'hCF; 4: return 8'h7E;
            6: return 8'hFE; 7: return 8'h0F; default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sm(input int a);
        case (a)
            0: return 8'hFF; 2: return 8'h1E; 3: return 8'h3F; 4: return 8'hFE;
            6: return 8'hFE; 7: return 8'h0F; default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] seq(input int k);
        case (k)
            0: return 8'hD5; 1: return 8'h7F; 2: return 8'h00; 3: return 8'hAA;
            4: return 8'h55; 5: return 8'hFF; 6: return 8'h80; default: return 8'h2A;
        endcase
    endfunction

    function automatic logic [7:0] exp_view(input int a);
        if (a != 5) return mreg[a];
        if (mreg[4][4]) return seq(id_k);
        return {2'b00, unlocked_in, 1'b0, tflag, sw_video, 1'b0, sw_pc_boot};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic chk_out(input string req);
        logic both;
        both = mreg[4][1] & mreg[4][3];
        chk({req, " host_hold"}, {7'd0, host_hold}, {7'd0, mreg[4][0] & ~both});
        chk({req, " sec_run"},   {7'd0, sec_run},   {7'd0, mreg[4][0] | both});
        chk("R11 outputs", {4'd0, video_sel, cart_map, win_en, aux_rom_en},
            {4'd0, mreg[4][2], mreg[4][1], mreg[3][1], mreg[3][0]});
    endtask

    // One clock cycle of stimulus starting at a falling edge.
    task automatic step(input logic hw, input logic hr, input int ha, input logic [7:0] hd,
                        input logic sw, input logic sr, input int sa, input logic [7:0] sd,
                        input logic to, input string req);
        logic [7:0] eh, es;
        logic mode_b, rd5;
        eh = exp_view(ha);
        es = exp_view(sa);
        h_wr = hw; h_rd = hr; h_addr = 3'(ha); h_wdata = hd;
        s_wr = sw; s_rd = sr; s_addr = 3'(sa); s_wdata = sd;
        bus_timeout = to;
        @(negedge clk);
        if (hr) chk({req, " host read"}, h_rdata, eh);
        if (sr) chk({req, " sec read"}, s_rdata, es);
        mode_b = mreg[4][4];
        rd5 = (hr && ha == 5) || (sr && sa == 5);
        if (!mode_b) id_k = 0;
        else if (rd5) id_k = (id_k + 1) % 8;
        if (to) tflag = 1'b1;
        else if (rd5) tflag = 1'b0;
        if (hw) begin
            mreg[ha] = (mreg[ha] & ~hm(ha)) | (hd & hm(ha));
            if (ha == 4) mreg[4][0] = mreg[4][0] | hd[0];
        end
        if (sw) begin
            mreg[sa] = (mreg[sa] & ~sm(sa)) | (sd & sm(sa));
            if (sa == 4) mreg[4][0] = mreg[4][0] & sd[0];
        end
        h_wr = 0; h_rd = 0; s_wr = 0; s_rd = 0; bus_timeout = 0;
    endtask

    task automatic hwr(input int a, input logic [7:0] d, input string req);
        step(1, 0, a, d, 0, 0, 0, 8'h00, 0, req);
    endtask
    task automatic swr(input int a, input logic [7:0] d, input string req);
        step(0, 0, 0, 8'h00, 1, 0, a, d, 0, req);
    endtask
    task automatic rd2(input int a, input string req);
        step(0, 1, a, 8'h00, 0, 1, a, 8'h00, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mreg[0] = 8'h00; mreg[1] = 8'hFF; mreg[2] = 8'hC0; mreg[3] = 8'h00;
        mreg[4] = 8'h80; mreg[5] = 8'h00; mreg[6] = 8'h00; mreg[7] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state on both ports and outputs.
        for (int a = 0; a < 8; a++) rd2(a, "R2 reset");
        chk_out("R2 reset");

        // R1 R3 R4: write patterns from each side to every offset except 4.
        for (int a = 0; a < 8; a++) begin
            if (a == 4) continue;
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h5A;
                hwr(a, pat, "R3 host write");
                rd2(a, "R1 R4 after host write");
                swr(a, ~pat, "R3 sec write");
                rd2(a, "R1 R4 after sec write");
                chk_out("R11 sweep");
            end
        end

        // R4: mailbox both directions.
        hwr(3, 8'h80, "R4"); swr(3, 8'h10, "R4");
        step(0, 1, 3, 8'h00, 0, 1, 3, 8'h00, 0, "R4 mailbox");

        // R5 handoff.
        hwr(4, 8'h01, "R5 set");  chk_out("R5 after host set");  rd2(4, "R5 readback");
        hwr(4, 8'h00, "R5 host0"); chk_out("R5 host zero no clear"); rd2(4, "R5 readback");
        swr(4, 8'h80, "R5 clear"); chk_out("R5 after sec clear");
        swr(4, 8'h81, "R5 sec1");  chk_out("R5 sec one no set"); rd2(4, "R5 readback");
        // R6 dual run.
        hwr(4, 8'h0A, "R6"); chk_out("R6 dual bit0 clear");
        hwr(4, 8'h0B, "R6"); chk_out("R6 dual bit0 set");
        hwr(4, 8'h05, "R11"); chk_out("R5 R11 single run video");
        // R3: host cannot clear bit 7, secondary can.
        swr(4, 8'h00, "R3"); rd2(4, "R3 sec cleared lock");
        hwr(4, 8'h80, "R3"); rd2(4, "R3 host cannot set lock");

        // R10 same-cycle writes.
        step(1, 0, 0, 8'h11, 1, 0, 0, 8'h22, 0, "R10"); rd2(0, "R10 shared bits");
        step(1, 0, 3, 8'hFF, 1, 0, 3, 8'h00, 0, "R10"); rd2(3, "R10 host only bits");
        step(1, 0, 4, 8'h01, 1, 0, 4, 8'h00, 0, "R10"); chk_out("R10 clear wins");
        rd2(4, "R10 handoff readback");
        step(1, 0, 4, 8'h01, 1, 0, 4, 8'h01, 0, "R10"); chk_out("R10 set lands");
        // R12 read old value during write.
        step(0, 1, 6, 8'h00, 1, 0, 6, 8'hF0, 0, "R12 read before write");
        rd2(6, "R12 new value");

        // R9 switch sweep.
        for (int k = 0; k < 8; k++) begin
            sw_pc_boot = k[0]; sw_video = k[1]; unlocked_in = k[2];
            rd2(5, "R9 switches");
        end
        sw_pc_boot = 1; sw_video = 0; unlocked_in = 1;

        // R7 timeout flag.
        step(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, "R7 pulse");
        step(0, 1, 5, 8'h00, 0, 0, 0, 8'h00, 0, "R7 flag set");
        step(0, 0, 0, 8'h00, 0, 1, 5, 8'h00, 0, "R7 flag cleared");
        step(0, 1, 5, 8'h00, 0, 0, 0, 8'h00, 1, "R7 pulse with read");
        step(0, 0, 0, 8'h00, 0, 1, 5, 8'h00, 0, "R7 set wins");
        step(0, 1, 5, 8'h00, 0, 0, 0, 8'h00, 0, "R7 cleared again");

        // R8 identification stream.
        hwr(4, 8'h10, "R8 mode on");
        for (int i = 0; i < 10; i++) begin
            if (i[0]) step(0, 1, 5, 8'h00, 0, 0, 0, 8'h00, 0, "R8 stream host");
            else      step(0, 0, 0, 8'h00, 0, 1, 5, 8'h00, 0, "R8 stream sec");
        end
        rd2(5, "R8 both ports same byte");
        rd2(5, "R8 single advance");
        hwr(4, 8'h00, "R8 mode off");
        rd2(5, "R8 status back");
        hwr(4, 8'h10, "R8 mode on again");
        rd2(5, "R8 restart");
        rd2(5, "R8 second byte");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule